// File: doc/BRIEF.md
# Power Management Event Register Bank

This block is a small bank of I/O-mapped registers that gathers power-management events and raises an interrupt for them. A host decodes it with a 16-bit I/O address. The main window is 64 bytes long, and its base (address bits [15:6]) is an input driven by a configuration register elsewhere. The main window holds three 16-bit registers:

- an event status register, which hardware events set and software clears by writing ones;
- an event enable register;
- a control register.

A second 16-byte window has its own base (address bits [15:4]). The block decodes it and claims accesses to it, but it holds no storage: reads of it return all ones and writes to it are dropped.

Reads are combinational: `ioRdData` always shows the location that `ioAddr` and `ioSize` currently select. Writes are applied on the rising clock edge while `ioWr` is high. The interrupt request is a level. It stays high while any status bit and its matching enable bit are both one, and software clears it by clearing those status bits or their enables.

Top module: `pwr_evt_bank`

## Requirements
- R1: An access falls in the main window when `ioAddr[15:6]` equals `mainBase`, and `ioAddr[5:0]` is then the byte offset. The status register is at offset 0x00, the enable register at 0x02 and the control register at 0x04.
- R2: A legal write to offset 0x00 clears each status bit whose `ioWrData` bit is one and leaves the other status bits unchanged.
- R3: The enable register (0x02) and the control register (0x04) take `ioWrData[15:0]` on a legal write. A legal read of any of the three registers returns the register value in bits [15:0] with zeros in bits [31:16].
- R4: A read of any main-window offset other than 0x00, 0x02 or 0x04 returns 0xFFFFFFFF, and a write to such an offset changes no register.
- R5: An access that is outside the main window but has `ioAddr[15:4]` equal to `auxBase` falls in the auxiliary window. It drives `ioHit` high and reads as 0xFFFFFFFF, and a write to it changes no register.
- R6: Reset (`rstN` low) clears the status, enable and control registers to zero, so `irq` is low after reset.
- R7: `ioSize` encodes the access size as 0 = byte, 1 = word, 2 = dword and 3 = reserved. The three registers accept only word accesses. Any other size at their offsets reads as 0xFFFFFFFF and, on a write, changes nothing.
- R8: A one on `evtPulse[i]` sets status bit i at the next clock edge. When the same edge also has a write that clears that bit, the bit ends up set.
- R9: `irq` is high exactly while the bitwise AND of the status and enable registers is nonzero.
- R10: An address outside both windows drives `ioHit` low, reads as 0xFFFFFFFF, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| mainBase | input | 10 | Base of the main window (address bits 15:6) |
| auxBase | input | 12 | Base of the auxiliary window (address bits 15:4) |
| ioAddr | input | 16 | I/O byte address |
| ioSize | input | 2 | Access size: 0 byte, 1 word, 2 dword, 3 reserved |
| ioWr | input | 1 | Write strobe, applied on the rising clock edge |
| ioWrData | input | 32 | Write data |
| ioRdData | output | 32 | Read data for the addressed location, combinational |
| ioHit | output | 1 | Address falls in either window |
| evtPulse | input | 16 | Hardware event inputs, one per status bit |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions check on every cycle that a status bit never turns on without an event the cycle before, that enable and control hold their values in cycles without a write, that the auxiliary window and every illegal size read all ones, and that `irq` stays low while enable is zero. Only the bench's scenarios show the rest:
- that each write-one-to-clear pattern removes exactly the bits asked for;
- that each of the 64 offsets and 4 sizes routes to the right register or to none;
- that setting wins over a clear in the same cycle;
- that moving `mainBase` moves the decode.

// File: rtl/pwr_evt_pkg.sv
package pwr_evt_pkg;

  localparam int STS_OFS = 0;
  localparam int EN_OFS  = 2;
  localparam int CTL_OFS = 4;

  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_WORD  = 2'd1;
  localparam logic [1:0] SZ_DWORD = 2'd2;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STS  = 2'd1,
    SEL_EN   = 2'd2,
    SEL_CTL  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    stsClr;
    logic    enWr;
    logic    ctlWr;
    regSel_e rdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/pwr_evt_ctrl.sv
module pwr_evt_ctrl
  import pwr_evt_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int MAIN_BYTES = 64,
  parameter int AUX_BYTES  = 16,
  localparam int MAIN_OFS_W = $clog2(MAIN_BYTES),
  localparam int AUX_OFS_W  = $clog2(AUX_BYTES)
) (
  input  logic [ADDR_W-MAIN_OFS_W-1:0] mainBase,
  input  logic [ADDR_W-AUX_OFS_W-1:0]  auxBase,
  input  logic [ADDR_W-1:0]            ioAddr,
  input  logic [1:0]                   ioSize,
  input  logic                         ioWr,
  output logic                         ioHit,
  output ctlStrobe_t                   strb
);

  logic                  mainHit;
  logic                  auxHit;
  logic [MAIN_OFS_W-1:0] ofs;
  logic [2:0]            sizeBit;
  logic [2:0]            sizeMask;
  logic                  legal;
  regSel_e               sel;

  // Mask of legal sizes for an offset: bit0 byte, bit1 word, bit2 dword.
  function automatic logic [2:0] legalSizes(input logic [MAIN_OFS_W-1:0] o);
    if (o == MAIN_OFS_W'(STS_OFS) || o == MAIN_OFS_W'(EN_OFS) ||
        o == MAIN_OFS_W'(CTL_OFS))
      return 3'b010;
    return 3'b000;
  endfunction

  assign mainHit = (ioAddr[ADDR_W-1:MAIN_OFS_W] == mainBase);
  assign auxHit  = !mainHit && (ioAddr[ADDR_W-1:AUX_OFS_W] == auxBase);
  assign ioHit   = mainHit | auxHit;
  assign ofs     = ioAddr[MAIN_OFS_W-1:0];

  always_comb begin
    unique case (ioSize)
      SZ_BYTE:  sizeBit = 3'b001;
      SZ_WORD:  sizeBit = 3'b010;
      SZ_DWORD: sizeBit = 3'b100;
      default:  sizeBit = 3'b000;
    endcase
  end

  assign sizeMask = legalSizes(ofs);
  assign legal    = mainHit && ((sizeMask & sizeBit) != 3'b000);

  always_comb begin
    sel = SEL_NONE;
    if (legal) begin
      if (ofs == MAIN_OFS_W'(STS_OFS))      sel = SEL_STS;
      else if (ofs == MAIN_OFS_W'(EN_OFS))  sel = SEL_EN;
      else if (ofs == MAIN_OFS_W'(CTL_OFS)) sel = SEL_CTL;
    end
  end

  always_comb begin
    strb.rdSel  = sel;
    strb.stsClr = ioWr && (sel == SEL_STS);
    strb.enWr   = ioWr && (sel == SEL_EN);
    strb.ctlWr  = ioWr && (sel == SEL_CTL);
  end

endmodule

// File: rtl/pwr_evt_dp.sv
module pwr_evt_dp
  import pwr_evt_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int DATA_W = 32,
  localparam int PAD_W = DATA_W - REG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [REG_W-1:0]  wrData,
  input  logic [REG_W-1:0]  evtPulse,
  output logic [DATA_W-1:0] rdData,
  output logic [REG_W-1:0]  stsQ,
  output logic [REG_W-1:0]  enQ,
  output logic [REG_W-1:0]  ctlQ,
  output logic              irq
);

  // Status bits: an event sets the bit, a write of one clears it, and the
  // set takes priority when both happen in the same cycle.
  for (genvar i = 0; i < REG_W; i++) begin : g_sts
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        stsQ[i] <= 1'b0;
      else if (evtPulse[i])
        stsQ[i] <= 1'b1;
      else if (strb.stsClr && wrData[i])
        stsQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ  <= '0;
      ctlQ <= '0;
    end else begin
      if (strb.enWr)  enQ  <= wrData;
      if (strb.ctlWr) ctlQ <= wrData;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_STS: rdData = {{PAD_W{1'b0}}, stsQ};
      SEL_EN:  rdData = {{PAD_W{1'b0}}, enQ};
      SEL_CTL: rdData = {{PAD_W{1'b0}}, ctlQ};
      default: rdData = '1;
    endcase
  end

  assign irq = |(stsQ & enQ);

endmodule

// File: rtl/pwr_evt_bank.sv
module pwr_evt_bank
  import pwr_evt_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int MAIN_BYTES = 64,
  parameter int AUX_BYTES  = 16,
  parameter int REG_W      = 16,
  parameter int DATA_W     = 32,
  localparam int MAIN_OFS_W = $clog2(MAIN_BYTES),
  localparam int AUX_OFS_W  = $clog2(AUX_BYTES)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADDR_W-MAIN_OFS_W-1:0] mainBase,
  input  logic [ADDR_W-AUX_OFS_W-1:0]  auxBase,
  input  logic [ADDR_W-1:0]            ioAddr,
  input  logic [1:0]                   ioSize,
  input  logic                         ioWr,
  input  logic [DATA_W-1:0]            ioWrData,
  output logic [DATA_W-1:0]            ioRdData,
  output logic                         ioHit,
  input  logic [REG_W-1:0]             evtPulse,
  output logic                         irq
);

  ctlStrobe_t       strb;
  logic [REG_W-1:0] stsQ;
  logic [REG_W-1:0] enQ;
  logic [REG_W-1:0] ctlQ;
  logic             unusedWrHi;

  // Only word accesses reach a register, so the upper data lanes are idle.
  assign unusedWrHi = ^ioWrData[DATA_W-1:REG_W];

  pwr_evt_ctrl #(
    .ADDR_W    (ADDR_W),
    .MAIN_BYTES(MAIN_BYTES),
    .AUX_BYTES (AUX_BYTES)
  ) u_ctrl (
    .mainBase(mainBase),
    .auxBase (auxBase),
    .ioAddr  (ioAddr),
    .ioSize  (ioSize),
    .ioWr    (ioWr),
    .ioHit   (ioHit),
    .strb    (strb)
  );

  pwr_evt_dp #(
    .REG_W (REG_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (ioWrData[REG_W-1:0]),
    .evtPulse(evtPulse),
    .rdData  (ioRdData),
    .stsQ    (stsQ),
    .enQ     (enQ),
    .ctlQ    (ctlQ),
    .irq     (irq)
  );

endmodule

// File: rtl/pwr_evt_chk.sv
module pwr_evt_chk #(
  parameter int ADDR_W     = 16,
  parameter int MAIN_BYTES = 64,
  parameter int AUX_BYTES  = 16,
  parameter int REG_W      = 16,
  parameter int DATA_W     = 32,
  localparam int MAIN_OFS_W = $clog2(MAIN_BYTES),
  localparam int AUX_OFS_W  = $clog2(AUX_BYTES)
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [ADDR_W-MAIN_OFS_W-1:0] mainBase,
  input logic [ADDR_W-AUX_OFS_W-1:0]  auxBase,
  input logic [ADDR_W-1:0]            ioAddr,
  input logic [1:0]                   ioSize,
  input logic                         ioWr,
  input logic [DATA_W-1:0]            ioRdData,
  input logic                         ioHit,
  input logic [REG_W-1:0]             evtPulse,
  input logic                         irq,
  input logic [REG_W-1:0]             stsQ,
  input logic [REG_W-1:0]             enQ,
  input logic [REG_W-1:0]             ctlQ
);

  logic inMain;
  logic inAux;
  assign inMain = (ioAddr[ADDR_W-1:MAIN_OFS_W] == mainBase);
  assign inAux  = !inMain && (ioAddr[ADDR_W-1:AUX_OFS_W] == auxBase);

  // R8 / R2: a status bit only turns on after an event in the cycle before
  p_no_spurious_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((stsQ & ~$past(stsQ) & ~$past(evtPulse)) == '0));

  // R3: enable and control hold their values without a write
  p_hold_without_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ioWr |=> ($stable(enQ) && $stable(ctlQ)));

  // R5: the auxiliary window claims the access and reads as all ones
  p_aux_all_ones_r5: assert property (@(posedge clk) disable iff (!rstN)
    inAux |-> (ioHit && ioRdData == '1));

  // R7: any size other than word reads as all ones
  p_illegal_size_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ioSize != 2'd1) |-> (ioRdData == '1));

  // R9: no interrupt while every enable bit is zero
  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    (enQ == '0) |-> !irq);

  // R10: outside both windows nothing is claimed
  p_no_hit_outside_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!inMain && !inAux) |-> (!ioHit && ioRdData == '1));

endmodule

bind pwr_evt_bank pwr_evt_chk #(
  .ADDR_W    (ADDR_W),
  .MAIN_BYTES(MAIN_BYTES),
  .AUX_BYTES (AUX_BYTES),
  .REG_W     (REG_W),
  .DATA_W    (DATA_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .mainBase(mainBase),
  .auxBase (auxBase),
  .ioAddr  (ioAddr),
  .ioSize  (ioSize),
  .ioWr    (ioWr),
  .ioRdData(ioRdData),
  .ioHit   (ioHit),
  .evtPulse(evtPulse),
  .irq     (irq),
  .stsQ    (stsQ),
  .enQ     (enQ),
  .ctlQ    (ctlQ)
);

// File: tb/pwr_evt_bank_bench.sv
module pwr_evt_bank_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  mainBase = 10'h010;
  logic [11:0] auxBase = 12'h050;
  logic [15:0] ioAddr = '0;
  logic [1:0]  ioSize = 2'd1;
  logic        ioWr = 1'b0;
  logic [31:0] ioWrData = '0;
  logic [31:0] ioRdData;
  logic        ioHit;
  logic [15:0] evtPulse = '0;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;

  logic [15:0] stsM = '0;
  logic [15:0] enM  = '0;
  logic [15:0] ctlM = '0;

  always #10 clk = ~clk;

  pwr_evt_bank u_pwr_evt_bank (
    .clk(clk), .rstN(rstN), .mainBase(mainBase), .auxBase(auxBase),
    .ioAddr(ioAddr), .ioSize(ioSize), .ioWr(ioWr), .ioWrData(ioWrData),
    .ioRdData(ioRdData), .ioHit(ioHit), .evtPulse(evtPulse), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mainAddr(input int ofs);
    return {mainBase, 6'(ofs)};
  endfunction

  task automatic rd(input logic [15:0] a, input logic [1:0] sz, output logic [31:0] v);
    @(negedge clk);
    ioAddr = a; ioSize = sz; ioWr = 1'b0;
    #1 v = ioRdData;
  endtask

  task automatic wr(input logic [15:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    ioAddr = a; ioSize = sz; ioWrData = d; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] e);
    @(negedge clk);
    evtPulse = e;
    @(negedge clk);
    evtPulse = '0;
  endtask

  task automatic checkRegs(input string req);
    logic [31:0] v;
    rd(mainAddr(0), 2'd1, v); check({req, " sts"}, v, {16'h0, stsM});
    rd(mainAddr(2), 2'd1, v); check({req, " en"},  v, {16'h0, enM});
    rd(mainAddr(4), 2'd1, v); check({req, " ctl"}, v, {16'h0, ctlM});
    check({req, " R9 irq"}, {31'h0, irq}, {31'h0, |(stsM & enM)});
  endtask

  initial begin : watchdog
    #3_000_000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    logic [31:0] v;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R6: registers start at zero
    checkRegs("R6 reset");
    rstN = 1'b1;
    @(negedge clk);
    checkRegs("R6 after release");

    // R8: events set status bits; R9: irq follows status AND enable
    pulse(16'h8001); stsM = 16'h8001;
    checkRegs("R8 event set");
    wr(mainAddr(2), 2'd1, 32'h0000_0001); enM = 16'h0001;
    checkRegs("R9 enabled");
    pulse(16'hFFFF); stsM = 16'hFFFF;

    // R1 R2 R3 R4 R7: write sweep over every offset and size of the main window
    for (int ofs = 0; ofs < 64; ofs++) begin
      for (int sz = 0; sz < 4; sz++) begin
        d = 32'h9E37_79B9 * (ofs * 4 + sz + 1);
        wr(mainAddr(ofs), 2'(sz), d);
        if (sz == 1) begin
          if (ofs == 0) stsM = stsM & ~d[15:0];
          else if (ofs == 2) enM = d[15:0];
          else if (ofs == 4) ctlM = d[15:0];
        end
        checkRegs("R4/R7 write sweep");
      end
      if (ofs % 8 == 7) pulse(16'hFFFF);
      if (ofs % 8 == 7) stsM = 16'hFFFF;
    end

    // R1 R3 R4 R7: read sweep over every offset and size
    for (int ofs = 0; ofs < 64; ofs++) begin
      for (int sz = 0; sz < 4; sz++) begin
        logic [31:0] exp;
        exp = 32'hFFFF_FFFF;
        if (sz == 1 && ofs == 0) exp = {16'h0, stsM};
        if (sz == 1 && ofs == 2) exp = {16'h0, enM};
        if (sz == 1 && ofs == 4) exp = {16'h0, ctlM};
        rd(mainAddr(ofs), 2'(sz), v);
        check("R4/R7 read sweep", v, exp);
        check("R1 hit", {31'h0, ioHit}, 32'h1);
      end
    end

    // R2: clear exactly the ones written
    wr(mainAddr(0), 2'd1, 32'h0000_0F0F); stsM = stsM & ~16'h0F0F;
    checkRegs("R2 partial clear");
    wr(mainAddr(0), 2'd1, 32'h0000_0000);
    checkRegs("R2 zero write");

    // R8: set wins over a clear in the same cycle
    @(negedge clk);
    ioAddr = mainAddr(0); ioSize = 2'd1; ioWrData = 32'h0000_FFFF; ioWr = 1'b1;
    evtPulse = 16'h0010;
    @(negedge clk);
    ioWr = 1'b0; evtPulse = '0;
    stsM = 16'h0010;
    checkRegs("R8 set beats clear");

    // R5: auxiliary window reads ones, writes are dropped
    for (int ofs = 0; ofs < 16; ofs++) begin
      for (int sz = 0; sz < 4; sz++) begin
        rd({auxBase, 4'(ofs)}, 2'(sz), v);
        check("R5 aux read", v, 32'hFFFF_FFFF);
        check("R5 aux hit", {31'h0, ioHit}, 32'h1);
        wr({auxBase, 4'(ofs)}, 2'(sz), 32'h0000_FFFF);
      end
    end
    checkRegs("R5 aux writes ignored");

    // R10: outside both windows
    rd(16'h0600, 2'd1, v);
    check("R10 outside read", v, 32'hFFFF_FFFF);
    check("R10 outside hit", {31'h0, ioHit}, 32'h0);
    wr(16'h0602, 2'd1, 32'h0000_5555);
    checkRegs("R10 outside write ignored");

    // R1: moving the base moves the decode
    mainBase = 10'h020;
    rd(16'h0402, 2'd1, v);
    check("R1 old base", v, 32'hFFFF_FFFF);
    check("R1 old base hit", {31'h0, ioHit}, 32'h0);
    wr(16'h0802, 2'd1, 32'h0000_00F0); enM = 16'h00F0;
    checkRegs("R1 new base");

    // R9: irq drops when status cleared
    pulse(16'h0020); stsM = stsM | 16'h0020;
    checkRegs("R9 raised");
    wr(mainAddr(0), 2'd1, 32'h0000_FFFF); stsM = '0;
    checkRegs("R9 dropped");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule